// File: doc/BRIEF.md
# Partial-Width Aliased General-Purpose Register File

This block holds eight 32-bit general-purpose registers that serve as both data and address operands. It has two combinational read ports and one write port. Every port carries a register index and a two-bit access-size code. The low four registers can also be reached through three narrower views: a 16-bit low half, a low byte and a second byte (bits 15:8). The upper four registers can be reached only at full width.

A read port returns the selected slice right-aligned and zero-extended onto a 32-bit bus. Sign extension is left to the consumer. A narrow write takes its data from the low bits of the write bus and merges it into the addressed register, so all other bits keep their value. A write and a read of the same register in the same cycle are bypassed, so the read sees the merged new value before the clock edge commits it. A narrow access to registers 4 to 7 is refused and flagged on the error output of that port.

Top module: `gpr_alias_file`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears all eight registers to zero. Right after reset, every legal read returns 0 with its error flag low.
- R2: A write with size code 2'b00 loads all 32 bits of any register from `wr_data`. From the next cycle, a 2'b00 read of that register returns that value.
- R3: Size code 2'b01 selects bits 15:0. A write replaces only those bits with `wr_data[15:0]`, and a read returns them with bits 31:16 of the bus at zero.
- R4: Size code 2'b10 selects bits 7:0. A write replaces only those bits with `wr_data[7:0]`, and a read returns them with bits 31:8 of the bus at zero.
- R5: Size code 2'b11 selects bits 15:8. A write copies `wr_data[7:0]` into them and keeps every other bit: 0x3A3F901D written with 0x44 becomes 0x3A3F441D. A read returns them in bits 7:0 of the bus, with bits 31:8 at zero.
- R6: Writing 0x12 through size 2'b11 and then 0x34 through size 2'b10 to the same register makes its 2'b01 read return 0x1234.
- R7: A size code other than 2'b00 on an index of 4 to 7 is illegal. On a read port it raises that port's error flag and returns 0. On the write port it raises `wr_err` and leaves the register unchanged.
- R8: When a committed write (`wr_en` high, `wr_err` low) targets the register a read port selects, the read returns the merged post-write value in that same cycle, sliced by the read's own size code.
- R9: The two read ports are independent. Each returns the data and error flag of its own index and size in the same cycle.
- R10: While `wr_en` is low, no register changes, whatever `wr_data`, `wr_idx` and `wr_size` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request |
| wr_idx | input | 3 | Write register index |
| wr_size | input | 2 | Write access-size code |
| wr_data | input | 32 | Write data, right-aligned |
| wr_err | output | 1 | Write request is illegal and is dropped |
| rd0_idx | input | 3 | Read port 0 register index |
| rd0_size | input | 2 | Read port 0 access-size code |
| rd0_data | output | 32 | Read port 0 zero-extended slice |
| rd0_err | output | 1 | Read port 0 request is illegal |
| rd1_idx | input | 3 | Read port 1 register index |
| rd1_size | input | 2 | Read port 1 access-size code |
| rd1_data | output | 32 | Read port 1 zero-extended slice |
| rd1_err | output | 1 | Read port 1 request is illegal |

## Verification
A lane-merging write and a read of the same register can fall in the same cycle, and then the read must return the merged value rather than the stored one. The bench sets this up by writing a byte or half lane while reading the same index, sometimes at another size. It judges the result from an expected value computed as the old contents with the new lane spliced in. A refused narrow write can also coincide with a read of the same register. That case is judged by reading the register at full width in the following cycle and finding it unchanged.

// File: rtl/gpr_pkg.sv
package gpr_pkg;

    typedef enum logic [1:0] {
        ACC_WORD = 2'b00,
        ACC_HALF = 2'b01,
        ACC_LOB  = 2'b10,
        ACC_HIB  = 2'b11
    } acc_size_e;

    localparam int HALF_W = 16;
    localparam int BYTE_W = 8;

    // Narrow views exist only on the low nalias registers.
    function automatic logic acc_legal(input int unsigned idx,
                                       input int unsigned nalias,
                                       input acc_size_e   sz);
        return (sz == ACC_WORD) || (idx < nalias);
    endfunction

endpackage

// File: rtl/gpr_lane_merge.sv
module gpr_lane_merge
    import gpr_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] old_val,
    input  logic [XLEN-1:0] new_data,
    input  acc_size_e       size,
    output logic [XLEN-1:0] merged
);
    localparam int HI_KEEP = XLEN - HALF_W;

    always_comb begin
        unique case (size)
            ACC_WORD: merged = new_data;
            ACC_HALF: merged = {old_val[XLEN-1:HALF_W], new_data[HALF_W-1:0]};
            ACC_LOB:  merged = {old_val[XLEN-1:BYTE_W], new_data[BYTE_W-1:0]};
            ACC_HIB:  merged = {old_val[XLEN-1:HALF_W], new_data[BYTE_W-1:0],
                                old_val[BYTE_W-1:0]};
            default:  merged = old_val;
        endcase
    end

    if (HI_KEEP < 0) begin : g_bad_width
        initial $display("gpr_lane_merge: XLEN below half width");
    end
endmodule

// File: rtl/gpr_slice_read.sv
module gpr_slice_read
    import gpr_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int IDXW   = 3,
    parameter int NALIAS = 4
) (
    input  logic [IDXW-1:0] idx,
    input  acc_size_e       size,
    input  logic [XLEN-1:0] reg_val,
    output logic [XLEN-1:0] data,
    output logic            err
);
    logic [XLEN-1:0] slice;

    always_comb begin
        unique case (size)
            ACC_WORD: slice = reg_val;
            ACC_HALF: slice = XLEN'(reg_val[HALF_W-1:0]);
            ACC_LOB:  slice = XLEN'(reg_val[BYTE_W-1:0]);
            ACC_HIB:  slice = XLEN'(reg_val[HALF_W-1:BYTE_W]);
            default:  slice = '0;
        endcase
    end

    always_comb begin
        err  = !acc_legal(int'(idx), NALIAS, size);
        data = err ? '0 : slice;
    end
endmodule

// File: rtl/gpr_alias_file.sv
module gpr_alias_file
    import gpr_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int NREG   = 8,
    parameter int NALIAS = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [$clog2(NREG)-1:0]  wr_idx,
    input  logic [1:0]               wr_size,
    input  logic [XLEN-1:0]          wr_data,
    output logic                     wr_err,
    input  logic [$clog2(NREG)-1:0]  rd0_idx,
    input  logic [1:0]               rd0_size,
    output logic [XLEN-1:0]          rd0_data,
    output logic                     rd0_err,
    input  logic [$clog2(NREG)-1:0]  rd1_idx,
    input  logic [1:0]               rd1_size,
    output logic [XLEN-1:0]          rd1_data,
    output logic                     rd1_err
);
    localparam int IDXW   = $clog2(NREG);
    localparam int NRPORT = 2;

    logic [XLEN-1:0] regs [NREG];
    logic [XLEN-1:0] wr_merged;
    logic            wr_commit;
    acc_size_e       wr_sz;

    logic [IDXW-1:0] rp_idx  [NRPORT];
    acc_size_e       rp_sz   [NRPORT];
    logic [XLEN-1:0] rp_src  [NRPORT];
    logic [XLEN-1:0] rp_data [NRPORT];
    logic            rp_err  [NRPORT];

    assign wr_sz     = acc_size_e'(wr_size);
    assign wr_commit = wr_en && acc_legal(int'(wr_idx), NALIAS, wr_sz);
    assign wr_err    = wr_en && !acc_legal(int'(wr_idx), NALIAS, wr_sz);

    gpr_lane_merge #(.XLEN(XLEN)) u_merge (
        .old_val (regs[wr_idx]),
        .new_data(wr_data),
        .size    (wr_sz),
        .merged  (wr_merged)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (wr_commit) begin
            regs[wr_idx] <= wr_merged;
        end
    end

    assign rp_idx[0] = rd0_idx;
    assign rp_idx[1] = rd1_idx;
    assign rp_sz[0]  = acc_size_e'(rd0_size);
    assign rp_sz[1]  = acc_size_e'(rd1_size);

    for (genvar p = 0; p < NRPORT; p++) begin : g_rport
        // Same-cycle bypass of the merged write value.
        assign rp_src[p] = (wr_commit && (wr_idx == rp_idx[p])) ? wr_merged
                                                                 : regs[rp_idx[p]];
        gpr_slice_read #(.XLEN(XLEN), .IDXW(IDXW), .NALIAS(NALIAS)) u_slice (
            .idx    (rp_idx[p]),
            .size   (rp_sz[p]),
            .reg_val(rp_src[p]),
            .data   (rp_data[p]),
            .err    (rp_err[p])
        );
    end

    assign rd0_data = rp_data[0];
    assign rd0_err  = rp_err[0];
    assign rd1_data = rp_data[1];
    assign rd1_err  = rp_err[1];
endmodule

// File: rtl/gpr_alias_chk.sv
module gpr_alias_chk #(
    parameter int XLEN   = 32,
    parameter int NREG   = 8,
    parameter int NALIAS = 4
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    wr_en,
    input logic [$clog2(NREG)-1:0] wr_idx,
    input logic [1:0]              wr_size,
    input logic [XLEN-1:0]         wr_data,
    input logic                    wr_err,
    input logic [$clog2(NREG)-1:0] rd0_idx,
    input logic [1:0]              rd0_size,
    input logic [XLEN-1:0]         rd0_data,
    input logic                    rd0_err,
    input logic [$clog2(NREG)-1:0] rd1_idx,
    input logic [1:0]              rd1_size,
    input logic [XLEN-1:0]         rd1_data,
    input logic                    rd1_err
);
    logic past_ok;
    always_ff @(posedge clk) past_ok <= 1'b1;

    logic wr_hits0;
    assign wr_hits0 = wr_en && !wr_err && (wr_idx == rd0_idx);

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(rst) && rd0_size == 2'b00 && !wr_hits0) |-> rd0_data == '0); // R1

    AST_HALF_ZEXT: assert property (@(posedge clk) disable iff (rst)
        (rd0_size == 2'b01) |-> rd0_data[XLEN-1:16] == '0); // R3

    AST_BYTE_ZEXT: assert property (@(posedge clk) disable iff (rst)
        (rd1_size[1]) |-> rd1_data[XLEN-1:8] == '0); // R4

    AST_ILLEGAL_READ: assert property (@(posedge clk) disable iff (rst)
        (rd0_err) |-> (rd0_data == '0 && rd0_size != 2'b00)); // R7

    AST_BYPASS_SAME_SIZE: assert property (@(posedge clk) disable iff (rst)
        (wr_hits0 && rd0_size == wr_size) |->
        rd0_data == ((wr_size == 2'b00) ? wr_data :
                     (wr_size == 2'b01) ? XLEN'(wr_data[15:0]) : XLEN'(wr_data[7:0]))); // R8

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !$past(rst) && (!$past(wr_en) || $past(wr_err)) && !wr_hits0
         && $stable(rd0_idx) && $stable(rd0_size)) |-> $stable(rd0_data)); // R10
endmodule

bind gpr_alias_file gpr_alias_chk #(.XLEN(XLEN), .NREG(NREG), .NALIAS(NALIAS)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_size(wr_size),
    .wr_data(wr_data), .wr_err(wr_err), .rd0_idx(rd0_idx), .rd0_size(rd0_size),
    .rd0_data(rd0_data), .rd0_err(rd0_err), .rd1_idx(rd1_idx), .rd1_size(rd1_size),
    .rd1_data(rd1_data), .rd1_err(rd1_err)
);

// File: tb/sim_gpr_alias_file.sv
module sim_gpr_alias_file;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [2:0]  wr_idx;
    logic [1:0]  wr_size;
    logic [31:0] wr_data;
    logic        wr_err;
    logic [2:0]  rd0_idx, rd1_idx;
    logic [1:0]  rd0_size, rd1_size;
    logic [31:0] rd0_data, rd1_data;
    logic        rd0_err, rd1_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    gpr_alias_file u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_size(wr_size),
        .wr_data(wr_data), .wr_err(wr_err), .rd0_idx(rd0_idx), .rd0_size(rd0_size),
        .rd0_data(rd0_data), .rd0_err(rd0_err), .rd1_idx(rd1_idx), .rd1_size(rd1_size),
        .rd1_data(rd1_data), .rd1_err(rd1_err)
    );

    typedef struct packed {
        logic        we;
        logic [2:0]  widx;
        logic [1:0]  wsz;
        logic [31:0] wdat;
        logic [2:0]  ridx;
        logic [1:0]  rsz;
        logic [31:0] expd;
        logic        eerr;
        logic [3:0]  req;
    } vec_t;

    // Sizes: 00 word, 01 half, 10 low byte, 11 second byte.
    localparam int NVEC = 20;
    localparam vec_t VTAB [NVEC] = '{
        '{1'b1, 3'd0, 2'b00, 32'h3A3F901D, 3'd0, 2'b00, 32'h3A3F901D, 1'b0, 4'd8},  // R8
        '{1'b1, 3'd0, 2'b11, 32'h00000044, 3'd0, 2'b00, 32'h3A3F441D, 1'b0, 4'd8},  // R8
        '{1'b0, 3'd0, 2'b00, 32'h0,        3'd0, 2'b00, 32'h3A3F441D, 1'b0, 4'd5},  // R5
        '{1'b1, 3'd1, 2'b11, 32'hFFFFFF12, 3'd1, 2'b00, 32'h00001200, 1'b0, 4'd5},  // R5
        '{1'b1, 3'd1, 2'b10, 32'h00000034, 3'd1, 2'b01, 32'h00001234, 1'b0, 4'd6},  // R6
        '{1'b0, 3'd0, 2'b00, 32'h0,        3'd1, 2'b01, 32'h00001234, 1'b0, 4'd6},  // R6
        '{1'b0, 3'd0, 2'b00, 32'h0,        3'd1, 2'b11, 32'h00000012, 1'b0, 4'd5},  // R5
        '{1'b1, 3'd2, 2'b00, 32'hDEADBEEF, 3'd2, 2'b00, 32'hDEADBEEF, 1'b0, 4'd2},  // R2
        '{1'b1, 3'd2, 2'b01, 32'hFFFF0123, 3'd3, 2'b00, 32'h00000000, 1'b0, 4'd1},  // R1
        '{1'b0, 3'd0, 2'b00, 32'h0,        3'd2, 2'b00, 32'hDEAD0123, 1'b0, 4'd3},  // R3
        '{1'b0, 3'd0, 2'b00, 32'h0,        3'd2, 2'b01, 32'h00000123, 1'b0, 4'd3},  // R3
        '{1'b1, 3'd2, 2'b10, 32'h777777AB, 3'd2, 2'b10, 32'h000000AB, 1'b0, 4'd4},  // R4
        '{1'b0, 3'd0, 2'b00, 32'h0,        3'd2, 2'b00, 32'hDEAD01AB, 1'b0, 4'd4},  // R4
        '{1'b1, 3'd5, 2'b00, 32'h55667788, 3'd5, 2'b00, 32'h55667788, 1'b0, 4'd2},  // R2
        '{1'b1, 3'd5, 2'b10, 32'h00000011, 3'd5, 2'b10, 32'h00000000, 1'b1, 4'd7},  // R7
        '{1'b0, 3'd0, 2'b00, 32'h0,        3'd5, 2'b00, 32'h55667788, 1'b0, 4'd7},  // R7
        '{1'b0, 3'd5, 2'b00, 32'h99999999, 3'd5, 2'b00, 32'h55667788, 1'b0, 4'd10}, // R10
        '{1'b0, 3'd0, 2'b00, 32'h0,        3'd5, 2'b00, 32'h55667788, 1'b0, 4'd10}, // R10
        '{1'b1, 3'd7, 2'b00, 32'hCAFEF00D, 3'd7, 2'b11, 32'h00000000, 1'b1, 4'd7},  // R7
        '{1'b0, 3'd0, 2'b00, 32'h0,        3'd7, 2'b00, 32'hCAFEF00D, 1'b0, 4'd2}   // R2
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic we, input logic [2:0] wi, input logic [1:0] ws,
                         input logic [31:0] wd, input logic [2:0] r0i, input logic [1:0] r0s,
                         input logic [2:0] r1i, input logic [1:0] r1s);
        @(negedge clk);
        wr_en = we; wr_idx = wi; wr_size = ws; wr_data = wd;
        rd0_idx = r0i; rd0_size = r0s; rd1_idx = r1i; rd1_size = r1s;
        #2;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        rst = 1'b1;
        drive(1'b0, 3'd0, 2'b00, 32'h0, 3'd0, 2'b00, 3'd7, 2'b00);
        @(posedge clk);
        @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1: reset state on both ports
        drive(1'b0, 3'd0, 2'b00, 32'h0, 3'd0, 2'b00, 3'd7, 2'b00);
        check("R1 rd0", rd0_data, 32'h0);
        check("R1 rd1", rd1_data, 32'h0);
        check("R1 err", {30'b0, rd0_err, rd1_err}, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            drive(VTAB[i].we, VTAB[i].widx, VTAB[i].wsz, VTAB[i].wdat,
                  VTAB[i].ridx, VTAB[i].rsz, 3'd0, 2'b00);
            check($sformatf("R%0d vec%0d data", VTAB[i].req, i), rd0_data, VTAB[i].expd);
            check($sformatf("R%0d vec%0d err", VTAB[i].req, i), {31'b0, rd0_err},
                  {31'b0, VTAB[i].eerr});
        end

        // R7: write error flag on illegal and legal narrow writes
        drive(1'b1, 3'd6, 2'b01, 32'h1111, 3'd6, 2'b00, 3'd0, 2'b00);
        check("R7 wr_err illegal", {31'b0, wr_err}, 32'h1);
        drive(1'b1, 3'd3, 2'b11, 32'h0, 3'd6, 2'b00, 3'd0, 2'b00);
        check("R7 wr_err legal", {31'b0, wr_err}, 32'h0);
        check("R7 idx6 untouched", rd0_data, 32'h0);

        // R9: independent ports in one cycle
        drive(1'b0, 3'd0, 2'b00, 32'h0, 3'd0, 2'b00, 3'd2, 2'b01);
        check("R9 rd0", rd0_data, 32'h3A3F441D);
        check("R9 rd1", rd1_data, 32'h000001AB);
        drive(1'b0, 3'd0, 2'b00, 32'h0, 3'd1, 2'b11, 3'd4, 2'b10);
        check("R9 rd0 legal", {rd0_err, rd0_data[30:0]}, 32'h00000012);
        check("R9 rd1 err", {31'b0, rd1_err}, 32'h1);
        check("R9 rd1 data", rd1_data, 32'h0);

        // R1: reset in mid-run clears stored values
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        drive(1'b0, 3'd0, 2'b00, 32'h0, 3'd2, 2'b00, 3'd5, 2'b00);
        check("R1 reclear rd0", rd0_data, 32'h0);
        check("R1 reclear rd1", rd1_data, 32'h0);

        done = 1'b1;
        finish_run();
    end
endmodule